// File: doc/BRIEF.md
# Timer and External-Interrupt Control Register

This block is an 8-bit control register that sits between two timers, two active-low external request pins and an interrupt controller. Software reads and writes it over a simple register port. The register holds a run enable for each timer and latches each timer's overflow pulse as a request flag. It also turns each external pin into a request flag. Each pin can be set to falling-edge or active-low level detection. The interrupt controller clears a flag through its acknowledge input when it vectors to that source. Timer counting, priority and vectoring stay outside the block.

Each request flag is one instance of a two-state cell. The states are `FLAG_IDLE` and `FLAG_PENDING`:
- The *raise* transition (IDLE→PENDING) happens on a set event, a software write of 1, or, in level mode, a low pin.
- The *drop* transition (PENDING→IDLE) happens on an acknowledge, a software write of 0, or, in level mode, a high pin.

Each pin has a synchronizer followed by a two-state tracker, with states `PIN_HIGH` and `PIN_LOW`:
- The *fall* transition (HIGH→LOW) is the falling edge.
- The *rise* transition (LOW→HIGH) re-arms the edge detector.

When timer 0 runs in its split mode (`t0_mode3` high), the second half of timer 0 takes over the timer 1 flag and the timer 1 run bit. Timer 1 keeps running, and its own mode setting stops it.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset every register bit is 0, so every run and request output is low and a read returns 8'h00.
- R2: While `reg_sel` is high, `reg_rdata` shows the register with bit 7 = timer 1 flag, 6 = timer 1 run, 5 = timer 0 flag, 4 = timer 0 run, 3 = pin 1 flag, 2 = pin 1 mode, 1 = pin 0 flag, 0 = pin 0 mode. While `reg_sel` is low it reads 0. Reading changes nothing.
- R3: A clock edge with `reg_sel` and `reg_we` both high loads `reg_wdata` into all eight bits, except where R4, R6 and R8 say otherwise. The run bits and the mode bits are plain storage.
- R4: A timer overflow pulse sets that timer's flag at the next edge, and this wins over a write or an acknowledge in the same cycle.
- R5: `ack_t0` or `ack_t1` clears the matching timer flag at the next edge, unless a set event occurs in the same cycle. A write in the same cycle wins over the acknowledge.
- R6: With its mode bit at 1 (edge mode), a high-to-low change on a pin sets that pin's flag three rising edges later. The flag then stays set while the pin is held low or returns high. A set event wins over a same-cycle write or acknowledge.
- R7: In edge mode, `ack_x0` or `ack_x1` clears the matching pin flag at the next edge.
- R8: With its mode bit at 0 (level mode), a pin flag equals the inverted pin value delayed by three rising edges. Acknowledges and written flag values have no effect on it.
- R9: While `t0_mode3` is high, the timer 1 flag is set by `t0_hi_ovf` and not by `t1_ovf`. In this mode `run_t0_hi` equals the timer 1 run bit and `run_t1` is held at 1.
- R10: While `t0_mode3` is low, the timer 1 flag is set by `t1_ovf` and `t0_hi_ovf` is ignored. In this mode `run_t1` equals the timer 1 run bit and `run_t0_hi` is 0.
- R11: At an edge where a pin's mode bit is written, that pin's flag is updated under the mode held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register address match |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| t0_hi_ovf | input | 1 | Overflow pulse of timer 0's second counter |
| t0_mode3 | input | 1 | Timer 0 is in split mode |
| int0_n | input | 1 | External request pin 0, active low |
| int1_n | input | 1 | External request pin 1, active low |
| ack_t0 | input | 1 | Vector acknowledge, timer 0 |
| ack_t1 | input | 1 | Vector acknowledge, timer 1 flag |
| ack_x0 | input | 1 | Vector acknowledge, pin 0 |
| ack_x1 | input | 1 | Vector acknowledge, pin 1 |
| run_t0 | output | 1 | Timer 0 run enable |
| run_t1 | output | 1 | Timer 1 run enable |
| run_t0_hi | output | 1 | Run enable of timer 0's second counter |
| req_t0 | output | 1 | Timer 0 request flag |
| req_t1 | output | 1 | Timer 1 request flag |
| req_x0 | output | 1 | Pin 0 request flag |
| req_x1 | output | 1 | Pin 1 request flag |

## Verification
Every flag cell and control bit drives an output port directly, so a wrong flag or run state appears at the ports on the clock after the faulty edge. A missed or doubled pin tracker transition shows up as a flag appearing or not appearing three edges after the pin change. A mode-3 routing error shows up as a timer 1 flag raised by the wrong pulse within one cycle. The bench's behavioural model compares all outputs and the read port on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/tic_pkg.sv
package tic_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 4;
    localparam int NUM_PINS  = 2;

    // Bit positions fixed by the read/write layout.
    localparam int POS_PIN0_MODE = 0;
    localparam int POS_PIN0_FLAG = 1;
    localparam int POS_PIN1_MODE = 2;
    localparam int POS_PIN1_FLAG = 3;
    localparam int POS_T0_RUN    = 4;
    localparam int POS_T0_FLAG   = 5;
    localparam int POS_T1_RUN    = 6;
    localparam int POS_T1_FLAG   = 7;

    typedef enum logic {
        PIN_HIGH = 1'b0,
        PIN_LOW  = 1'b1
    } pin_state_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    // Flag cell index -> register bit: 0 timer0, 1 timer1, 2 pin0, 3 pin1
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return POS_T0_FLAG;
            1:       return POS_T1_FLAG;
            2:       return POS_PIN0_FLAG;
            default: return POS_PIN1_FLAG;
        endcase
    endfunction

endpackage

// File: rtl/tic_pin_detect.sv
module tic_pin_detect
    import tic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_low,
    output logic fall
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          synced;
    pin_state_e    state_q;
    pin_state_e    state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin_n};
        end
    end

    assign synced = sync_q[LAST];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: fall (HIGH->LOW), rise (LOW->HIGH)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_HIGH: if (!synced) state_d = PIN_LOW;
            PIN_LOW:  if (synced)  state_d = PIN_HIGH;
        endcase
    end

    // Outputs
    always_comb begin
        level_low = !synced;
        fall      = (state_q == PIN_HIGH) && !synced;
    end

    // One edge per low period
    p_single_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tic_flag_cell.sv
module tic_flag_cell
    import tic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic follow_en,
    input  logic follow_val,
    input  logic set_ev,
    input  logic wr_en,
    input  logic wr_val,
    input  logic ack,
    output logic flag
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Priority: level tracking, set, write, acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (follow_en) begin
                    if (follow_val) state_d = FLAG_PENDING;
                end else if (set_ev || (wr_en && wr_val)) begin
                    state_d = FLAG_PENDING;
                end
            end
            FLAG_PENDING: begin
                if (follow_en) begin
                    if (!follow_val) state_d = FLAG_IDLE;
                end else if (set_ev) begin
                    state_d = FLAG_PENDING;
                end else if (wr_en) begin
                    if (!wr_val) state_d = FLAG_IDLE;
                end else if (ack) begin
                    state_d = FLAG_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_PENDING);
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!follow_en && set_ev) |=> flag);

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!follow_en && !set_ev && !wr_en && ack) |=> !flag);

    p_level_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        follow_en |=> (flag == $past(follow_val)));

endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
    import tic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             t0_ovf,
    input  logic             t1_ovf,
    input  logic             t0_hi_ovf,
    input  logic             t0_mode3,
    input  logic             int0_n,
    input  logic             int1_n,
    input  logic             ack_t0,
    input  logic             ack_t1,
    input  logic             ack_x0,
    input  logic             ack_x1,
    output logic             run_t0,
    output logic             run_t1,
    output logic             run_t0_hi,
    output logic             req_t0,
    output logic             req_t1,
    output logic             req_x0,
    output logic             req_x1
);

    logic                 wr;
    logic                 tr0_q, tr1_q;
    logic [NUM_PINS-1:0]  edge_mode_q;
    logic [NUM_PINS-1:0]  pin_n;
    logic [NUM_PINS-1:0]  pin_low;
    logic [NUM_PINS-1:0]  pin_fall;
    logic [NUM_PINS-1:0]  pin_ack;
    logic [NUM_FLAGS-1:0] f_set, f_ack, f_fen, f_fval, f_wval, f_q;
    logic                 tf1_src;

    assign wr      = reg_sel && reg_we;
    assign pin_n   = {int1_n, int0_n};
    assign pin_ack = {ack_x1, ack_x0};

    // Plain control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tr0_q       <= 1'b0;
            tr1_q       <= 1'b0;
            edge_mode_q <= '0;
        end else if (wr) begin
            tr0_q          <= reg_wdata[POS_T0_RUN];
            tr1_q          <= reg_wdata[POS_T1_RUN];
            edge_mode_q[0] <= reg_wdata[POS_PIN0_MODE];
            edge_mode_q[1] <= reg_wdata[POS_PIN1_MODE];
        end
    end

    // Split mode hands the timer 1 flag to timer 0's second counter
    assign tf1_src = t0_mode3 ? t0_hi_ovf : t1_ovf;

    assign f_set[0]  = t0_ovf;
    assign f_set[1]  = tf1_src;
    assign f_ack[0]  = ack_t0;
    assign f_ack[1]  = ack_t1;
    assign f_fen[1:0]  = '0;
    assign f_fval[1:0] = '0;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        tic_pin_detect #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (pin_n[p]),
            .level_low(pin_low[p]),
            .fall     (pin_fall[p])
        );
        assign f_set[2+p]  = pin_fall[p] && edge_mode_q[p];
        assign f_ack[2+p]  = pin_ack[p];
        assign f_fen[2+p]  = !edge_mode_q[p];
        assign f_fval[2+p] = pin_low[p];
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        assign f_wval[i] = reg_wdata[flag_pos(i)];
        tic_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .follow_en (f_fen[i]),
            .follow_val(f_fval[i]),
            .set_ev    (f_set[i]),
            .wr_en     (wr),
            .wr_val    (f_wval[i]),
            .ack       (f_ack[i]),
            .flag      (f_q[i])
        );
    end

    always_comb begin
        req_t0    = f_q[0];
        req_t1    = f_q[1];
        req_x0    = f_q[2];
        req_x1    = f_q[3];
        run_t0    = tr0_q;
        run_t1    = t0_mode3 ? 1'b1 : tr1_q;
        run_t0_hi = t0_mode3 && tr1_q;
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[POS_T1_FLAG]   = f_q[1];
            reg_rdata[POS_T1_RUN]    = tr1_q;
            reg_rdata[POS_T0_FLAG]   = f_q[0];
            reg_rdata[POS_T0_RUN]    = tr0_q;
            reg_rdata[POS_PIN1_FLAG] = f_q[3];
            reg_rdata[POS_PIN1_MODE] = edge_mode_q[1];
            reg_rdata[POS_PIN0_FLAG] = f_q[2];
            reg_rdata[POS_PIN0_MODE] = edge_mode_q[0];
        end
    end

    p_t1ovf_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_mode3 && t1_ovf && !t0_hi_ovf && !req_t1 && !wr) |=> !req_t1);

    p_hiovf_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!t0_mode3 && t0_hi_ovf && !t1_ovf && !req_t1 && !wr) |=> !req_t1);

    p_edge_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_q[0] && ack_x0 && !pin_fall[0] && !wr) |=> !req_x0);

endmodule

// File: tb/tmr_irq_ctl_test.sv
module tmr_irq_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 0, reg_we = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       t0_ovf = 0, t1_ovf = 0, t0_hi_ovf = 0, t0_mode3 = 0;
    logic       int0_n = 1, int1_n = 1;
    logic       ack_t0 = 0, ack_t1 = 0, ack_x0 = 0, ack_x1 = 0;
    logic       run_t0, run_t1, run_t0_hi;
    logic       req_t0, req_t1, req_x0, req_x1;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_tag  = "R1";
    bit    chk_on   = 0;

    always #2.5 clk = ~clk;

    tmr_irq_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .t0_ovf(t0_ovf),
        .t1_ovf(t1_ovf), .t0_hi_ovf(t0_hi_ovf), .t0_mode3(t0_mode3),
        .int0_n(int0_n), .int1_n(int1_n), .ack_t0(ack_t0), .ack_t1(ack_t1),
        .ack_x0(ack_x0), .ack_x1(ack_x1), .run_t0(run_t0), .run_t1(run_t1),
        .run_t0_hi(run_t0_hi), .req_t0(req_t0), .req_t1(req_t1),
        .req_x0(req_x0), .req_x1(req_x1)
    );

    // Behavioural reference model
    bit m_tf0, m_tf1, m_tr0, m_tr1;
    bit m_ie[2];
    bit m_it[2];
    bit m_pipe[2][$];   // synchronizer contents, oldest first
    bit m_prev[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_tf0, m_tf1, m_tr0, m_tr1} = 4'b0;
            for (int p = 0; p < 2; p++) begin
                m_ie[p] = 0; m_it[p] = 0; m_prev[p] = 1;
                m_pipe[p] = '{1, 1};
            end
        end else begin
            bit w;
            bit pins[2];
            bit acks[2];
            bit s2[2];
            bit src1;
            w = reg_sel && reg_we;
            pins[0] = int0_n; pins[1] = int1_n;
            acks[0] = ack_x0; acks[1] = ack_x1;
            src1 = t0_mode3 ? t0_hi_ovf : t1_ovf;
            if (t0_ovf) m_tf0 = 1; else if (w) m_tf0 = reg_wdata[5]; else if (ack_t0) m_tf0 = 0;
            if (src1)   m_tf1 = 1; else if (w) m_tf1 = reg_wdata[7]; else if (ack_t1) m_tf1 = 0;
            for (int p = 0; p < 2; p++) begin
                s2[p] = m_pipe[p][0];
                if (!m_it[p]) m_ie[p] = !s2[p];
                else if (m_prev[p] && !s2[p]) m_ie[p] = 1;
                else if (w) m_ie[p] = reg_wdata[1 + 2*p];
                else if (acks[p]) m_ie[p] = 0;
                m_prev[p] = s2[p];
                void'(m_pipe[p].pop_front());
                m_pipe[p].push_back(pins[p]);
            end
            if (w) begin
                m_tr0 = reg_wdata[4]; m_tr1 = reg_wdata[6];
                m_it[0] = reg_wdata[0]; m_it[1] = reg_wdata[2];
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            chk("req_t0", req_t0, m_tf0);
            chk("req_t1", req_t1, m_tf1);
            chk("req_x0", req_x0, m_ie[0]);
            chk("req_x1", req_x1, m_ie[1]);
            chk("run_t0", run_t0, m_tr0);
            chk("run_t1", run_t1, t0_mode3 ? 1 : m_tr1);
            chk("run_t0_hi", run_t0_hi, t0_mode3 && m_tr1);
            chk("rdata", reg_rdata, reg_sel ?
                {m_tf1, m_tr1, m_tf0, m_tr0, m_ie[1], m_it[1], m_ie[0], m_it[0]} : 8'h00);
        end
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr_reg(logic [7:0] v);
        reg_sel = 1; reg_we = 1; reg_wdata = v;
        cyc(1);
        reg_we = 0; reg_sel = 0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        cyc(4);
        rst_n = 1;
        chk_on = 1;
        // R1: reset value
        cur_tag = "R1";
        reg_sel = 1;
        cyc(1);
        chk("reset read", reg_rdata, 8'h00);
        chk("reset outputs", {run_t0, run_t1, run_t0_hi, req_t0, req_t1, req_x0, req_x1}, 0);
        // R3: plain bits
        cur_tag = "R3";
        wr_reg(8'h51);
        reg_sel = 1; cyc(1);
        chk("write readback", reg_rdata, 8'h51);
        // R2: read without side effects, deselected reads 0
        cur_tag = "R2";
        cyc(3);
        reg_sel = 0; cyc(1);
        chk("idle read", reg_rdata, 8'h00);
        // R4: overflow sets, wins over write of 0 and ack
        cur_tag = "R4";
        t0_ovf = 1; cyc(1); t0_ovf = 0; cyc(1);
        chk("tf0 set", req_t0, 1);
        t0_ovf = 1; ack_t0 = 1; wr_reg(8'h50); t0_ovf = 0; ack_t0 = 0; cyc(1);
        chk("set beats write/ack", req_t0, 1);
        // R5: ack clears, write beats ack
        cur_tag = "R5";
        ack_t0 = 1; cyc(1); ack_t0 = 0; cyc(1);
        chk("ack clears tf0", req_t0, 0);
        ack_t0 = 1; wr_reg(8'h70); ack_t0 = 0; cyc(1);
        chk("write beats ack", req_t0, 1);
        wr_reg(8'h51);
        // R6: pin 0 edge mode (bit0 = 1)
        cur_tag = "R6";
        int0_n = 0; cyc(2);
        chk("edge not yet", req_x0, 0);
        cyc(1);
        chk("edge seen", req_x0, 1);
        int0_n = 1; cyc(5);
        chk("edge latched", req_x0, 1);
        // R7: ack clears in edge mode
        cur_tag = "R7";
        ack_x0 = 1; cyc(1); ack_x0 = 0; cyc(1);
        chk("edge ack", req_x0, 0);
        int0_n = 0; cyc(1); int0_n = 1; cyc(6);
        ack_x0 = 1; cyc(1); ack_x0 = 0; cyc(2);
        // R8: pin 1 level mode (bit2 = 0)
        cur_tag = "R8";
        int1_n = 0; cyc(4);
        chk("level low", req_x1, 1);
        ack_x1 = 1; wr_reg(8'h51); ack_x1 = 0; cyc(1);
        chk("ack ignored", req_x1, 1);
        int1_n = 1; cyc(4);
        chk("level released", req_x1, 0);
        // R11: switch pin 1 to edge while pin low
        cur_tag = "R11";
        int1_n = 0; cyc(4);
        wr_reg(8'h55); cyc(2);
        chk("flag kept after mode change", req_x1, 1);
        ack_x1 = 1; cyc(1); ack_x1 = 0; int1_n = 1; cyc(4);
        wr_reg(8'h51); cyc(1);
        // R9: split mode routing
        cur_tag = "R9";
        t0_mode3 = 1; cyc(1);
        t1_ovf = 1; cyc(1); t1_ovf = 0; cyc(1);
        chk("t1_ovf ignored", req_t1, 0);
        chk("hi run", run_t0_hi, 1);
        t0_hi_ovf = 1; cyc(1); t0_hi_ovf = 0; cyc(1);
        chk("hi ovf sets", req_t1, 1);
        ack_t1 = 1; cyc(1); ack_t1 = 0;
        wr_reg(8'h11); cyc(1);
        chk("t1 forced on", run_t1, 1);
        chk("hi stopped", run_t0_hi, 0);
        // R10: normal routing
        cur_tag = "R10";
        t0_mode3 = 0; cyc(1);
        t0_hi_ovf = 1; cyc(1); t0_hi_ovf = 0; cyc(1);
        chk("hi ovf ignored", req_t1, 0);
        chk("t1 run follows bit", run_t1, 0);
        t1_ovf = 1; cyc(1); t1_ovf = 0; cyc(1);
        chk("t1 ovf sets", req_t1, 1);
        cyc(3);
        summary();
    end

endmodule